// File: doc/BRIEF.md
# Autocorrelation-Sign Loop Gain Tracker

This block slowly adapts the gain term that a digitally controlled regulator's solver uses. On every sample strobe it takes the sign bit of the quantized output error and compares it with the sign bit of the previous counted sample. A mismatch means the error changed sign. Over a fixed window of samples, sign changes pull a signed tally down and sign repeats push it up. The final tally is therefore a coarse estimate of the lag-1 autocorrelation sign of the error.

When a window completes, a strongly positive tally indicates an over-damped loop, and the gain register steps up. A strongly negative tally indicates an under-damped loop, and the gain register steps down. A tally inside the dead band leaves the gain alone. The step size, the dead-band threshold and the gain limits are inputs, so software or fuses can set them. An enable input pauses adaptation without losing the partial window.

Top module: `acorr_gain_tracker`

## Requirements
- R1: While `rst_ni` is low, and until the first window completes after reset, `gain_o` equals the parameter `GAIN_INIT` (default 256) and the tally is zero.
- R2: A counted sample compares `err_sign_i` with the sign of the previous counted or priming sample. The first strobe after reset, and the first strobe after `en_i` returns high, only records the sign and is not counted.
- R3: A counted sample whose sign matches the stored sign adds +1 to the tally, and one whose sign differs adds -1. The tally therefore stays within ±`WIN_LEN`.
- R4: A decision is made exactly once per `WIN_LEN` (default 40) counted samples, at the clock edge of the last one. Any new `gain_o` is visible from that edge onward, and the next window starts from a zero tally.
- R5: A final tally ≥ `thresh_i` raises `gain_o` by `step_i`, saturating at `gain_max_i`.
- R6: A final tally ≤ -`thresh_i` lowers `gain_o` by `step_i`, saturating at `gain_min_i`.
- R7: A final tally strictly between -`thresh_i` and +`thresh_i` leaves `gain_o` unchanged.
- R8: While `en_i` is low, strobes are ignored. `gain_o`, the tally and the window position are held, so a paused window resumes where it stopped.
- R9: In cycles without `strobe_i`, `err_sign_i` has no effect on the tally or on `gain_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Adaptation enable |
| strobe_i | input | 1 | Error sample valid |
| err_sign_i | input | 1 | Sign bit (MSB) of the quantized error sample |
| thresh_i | input | CNT_W (7) | Dead-band magnitude, unsigned (typical value 8) |
| step_i | input | GAIN_W (10) | Gain step size |
| gain_min_i | input | GAIN_W (10) | Lower gain limit |
| gain_max_i | input | GAIN_W (10) | Upper gain limit |
| gain_o | output | GAIN_W (10) | Tracked solver gain |

## Verification
The stored sign and the tally are both updated at the edge that captures a strobe. The gain decision falls on the edge of the window's last counted strobe, so `gain_o` moves at that edge and at no other. The bench drives inputs on falling edges and holds each strobe for one cycle. It then reads `gain_o` on the next falling edge, half a cycle after the deciding edge, and compares it against a model that is stepped only at its own count of `WIN_LEN` counted samples. Checks during pauses and strobe-free cycles read `gain_o` on the same falling-edge grid. The real test of R8 and R2 is whether a later window's decision comes out as the model predicts.

// File: rtl/acgt_pkg.sv
package acgt_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } gain_dec_e;
endpackage

// File: rtl/acgt_sign_corr.sv
module acgt_sign_corr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic sign_i,
  output logic corr_vld_o,
  output logic corr_flip_o
);
  logic primed_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      prev_q   <= 1'b0;
    end else if (!en_i) begin
      primed_q <= 1'b0;            // re-prime after a pause
    end else if (strobe_i) begin
      prev_q   <= sign_i;
      primed_q <= 1'b1;
    end
  end

  assign corr_vld_o  = en_i & strobe_i & primed_q;
  assign corr_flip_o = sign_i ^ prev_q;
endmodule

// File: rtl/acgt_win_accum.sv
module acgt_win_accum #(
  parameter int WIN_LEN = 40,
  parameter int CNT_W   = $clog2(WIN_LEN + 1) + 1,
  parameter int IDX_W   = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    flip_i,
  output logic                    done_o,
  output logic signed [CNT_W-1:0] total_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

  logic signed [CNT_W-1:0] acc_q;
  logic        [IDX_W-1:0] idx_q;
  logic signed [CNT_W-1:0] delta;

  assign delta   = flip_i ? -CNT_W'(1) : CNT_W'(1);
  assign total_o = acc_q + delta;
  assign done_o  = vld_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (vld_i) begin
      if (idx_q == LAST_IDX) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= total_o;
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/acgt_gain_step.sv
module acgt_gain_step
  import acgt_pkg::*;
#(
  parameter int GAIN_W    = 10,
  parameter int CNT_W     = 7,
  parameter int GAIN_INIT = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    done_i,
  input  logic signed [CNT_W-1:0] total_i,
  input  logic        [CNT_W-1:0] thresh_i,
  input  logic       [GAIN_W-1:0] step_i,
  input  logic       [GAIN_W-1:0] gain_min_i,
  input  logic       [GAIN_W-1:0] gain_max_i,
  output logic       [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0]     gain_q, gain_up, gain_dn;
  logic [GAIN_W:0]       up_sum, dn_floor;
  logic signed [CNT_W:0] tot_x, thr_x;
  gain_dec_e             dec;

  assign tot_x = {total_i[CNT_W-1], total_i};
  assign thr_x = $signed({1'b0, thresh_i});

  always_comb begin
    if (tot_x >= thr_x)       dec = DEC_UP;
    else if (tot_x <= -thr_x) dec = DEC_DOWN;
    else                      dec = DEC_HOLD;
  end

  assign up_sum   = {1'b0, gain_q} + {1'b0, step_i};
  assign dn_floor = {1'b0, gain_min_i} + {1'b0, step_i};
  assign gain_up  = (up_sum > {1'b0, gain_max_i}) ? gain_max_i : up_sum[GAIN_W-1:0];
  assign gain_dn  = ({1'b0, gain_q} < dn_floor) ? gain_min_i : gain_q - step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= GAIN_W'(GAIN_INIT);
    end else if (done_i) begin
      case (dec)
        DEC_UP:   gain_q <= gain_up;
        DEC_DOWN: gain_q <= gain_dn;
        default:  gain_q <= gain_q;
      endcase
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/acorr_gain_tracker.sv
module acorr_gain_tracker #(
  parameter int GAIN_W    = 10,
  parameter int WIN_LEN   = 40,
  parameter int GAIN_INIT = 256,
  localparam int CNT_W    = $clog2(WIN_LEN + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              strobe_i,
  input  logic              err_sign_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [GAIN_W-1:0] step_i,
  input  logic [GAIN_W-1:0] gain_min_i,
  input  logic [GAIN_W-1:0] gain_max_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic                    corr_vld, corr_flip, win_done;
  logic signed [CNT_W-1:0] win_total;

  acgt_sign_corr u_corr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .strobe_i    (strobe_i),
    .sign_i      (err_sign_i),
    .corr_vld_o  (corr_vld),
    .corr_flip_o (corr_flip)
  );

  acgt_win_accum #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (corr_vld),
    .flip_i  (corr_flip),
    .done_o  (win_done),
    .total_o (win_total)
  );

  acgt_gain_step #(.GAIN_W(GAIN_W), .CNT_W(CNT_W), .GAIN_INIT(GAIN_INIT)) u_gain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (win_done),
    .total_i    (win_total),
    .thresh_i   (thresh_i),
    .step_i     (step_i),
    .gain_min_i (gain_min_i),
    .gain_max_i (gain_max_i),
    .gain_o     (gain_o)
  );
endmodule

// File: rtl/acorr_gain_tracker_chk.sv
module acorr_gain_tracker_chk #(
  parameter int GAIN_W  = 10,
  parameter int WIN_LEN = 40,
  parameter int CNT_W   = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    strobe_i,
  input logic        [CNT_W-1:0] thresh_i,
  input logic       [GAIN_W-1:0] step_i,
  input logic       [GAIN_W-1:0] gain_min_i,
  input logic       [GAIN_W-1:0] gain_max_i,
  input logic       [GAIN_W-1:0] gain_o,
  input logic                    done_i,
  input logic signed [CNT_W-1:0] total_i
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_total_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (total_i <= CNT_W'(WIN_LEN)) && (total_i >= -CNT_W'(WIN_LEN)));

  p_change_at_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (gain_o != $past(gain_o)) |-> $past(done_i));

  p_rise_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (gain_o > $past(gain_o)) |->
      ((gain_o - $past(gain_o)) <= $past(step_i)) && (gain_o <= $past(gain_max_i)));

  p_fall_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (gain_o < $past(gain_o)) |->
      (($past(gain_o) - gain_o) <= $past(step_i)) && (gain_o >= $past(gain_min_i)));

  p_dead_band_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ($signed({total_i[CNT_W-1], total_i}) < $signed({1'b0, thresh_i}))
            && ($signed({total_i[CNT_W-1], total_i}) > -$signed({1'b0, thresh_i})))
    |=> $stable(gain_o));

  p_frozen_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(gain_o));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(gain_o));
endmodule

bind acorr_gain_tracker acorr_gain_tracker_chk #(
  .GAIN_W(GAIN_W), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .strobe_i   (strobe_i),
  .thresh_i   (thresh_i),
  .step_i     (step_i),
  .gain_min_i (gain_min_i),
  .gain_max_i (gain_max_i),
  .gain_o     (gain_o),
  .done_i     (win_done),
  .total_i    (win_total)
);

// File: tb/acorr_gain_tracker_tb_top.sv
module acorr_gain_tracker_tb_top;
  localparam int GAIN_W = 10;
  localparam int WIN    = 40;
  localparam int INIT   = 256;
  localparam int CNT_W  = $clog2(WIN + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, strobe = 1'b0, sgn = 1'b0;
  logic [CNT_W-1:0]  thr = CNT_W'(8);
  logic [GAIN_W-1:0] step = GAIN_W'(5), gmin = GAIN_W'(100), gmax = GAIN_W'(400);
  logic [GAIN_W-1:0] gain;

  int errors = 0, checks = 0;
  int m_gain = INIT;
  logic m_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  acorr_gain_tracker #(.GAIN_W(GAIN_W), .WIN_LEN(WIN), .GAIN_INIT(INIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .strobe_i(strobe), .err_sign_i(sgn),
    .thresh_i(thr), .step_i(step), .gain_min_i(gmin), .gain_max_i(gmax), .gain_o(gain)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: gain actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe, then one idle cycle with the opposite sign on the pin (R9)
  task automatic pulse(input logic s);
    @(negedge clk);
    strobe = 1'b1; sgn = s;
    @(negedge clk);
    strobe = 1'b0; sgn = ~s;
  endtask

  function automatic int decide(input int g, input int total);
    int r = g;
    if (total >= int'(thr)) r = (g + int'(step) > int'(gmax)) ? int'(gmax) : g + int'(step);
    else if (total <= -int'(thr)) r = (g < int'(gmin) + int'(step)) ? int'(gmin) : g - int'(step);
    return r;
  endfunction

  // full window: first k counted samples flip sign, the rest repeat it
  task automatic window(input int k, input string req);
    for (int i = 0; i < WIN; i++) begin
      logic s = (i < k) ? ~m_prev : m_prev;
      pulse(s);
      m_prev = s;
      if (i < WIN - 1) check("R9", int'(gain), m_gain);
    end
    m_gain = decide(m_gain, WIN - 2 * k);
    check(req, int'(gain), m_gain);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(gain), INIT);
    rst_n = 1'b1; en = 1'b1;
    // priming strobe (R2): a flip here would change the first window's outcome
    pulse(1'b1); m_prev = 1'b1;
    check("R2", int'(gain), INIT);

    // sweep every flip count; tally = 40 - 2k
    for (int k = 0; k <= WIN; k++) begin
      int t = WIN - 2 * k;
      window(k, (t >= 8) ? "R5" : (t <= -8) ? "R6" : "R7");
    end

    // saturation
    step = GAIN_W'(50);
    for (int w = 0; w < 4; w++) window(0, "R5");
    check("R5", int'(gain), 400);
    for (int w = 0; w < 8; w++) window(WIN, "R6");
    check("R6", int'(gain), 100);

    // pause mid-window: 20 repeats, disabled flips, re-prime with a flip, 20 repeats
    step = GAIN_W'(5);
    for (int i = 0; i < 20; i++) pulse(m_prev);
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pulse(~m_prev); m_prev = ~m_prev;
      check("R8", int'(gain), m_gain);
    end
    @(negedge clk); en = 1'b1;
    pulse(~m_prev); m_prev = ~m_prev;     // priming only (R2)
    for (int i = 0; i < 20; i++) pulse(m_prev);
    m_gain = decide(m_gain, 40);
    check("R8", int'(gain), m_gain);

    // first window after a reset starts from a cleared tally: 39 repeats, no decision
    for (int i = 0; i < 10; i++) pulse(~m_prev);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    m_gain = INIT;
    check("R1", int'(gain), INIT);
    rst_n = 1'b1;
    pulse(1'b0); m_prev = 1'b0;
    for (int i = 0; i < WIN - 1; i++) pulse(1'b0);
    check("R4", int'(gain), INIT);
    pulse(1'b0);
    m_gain = decide(m_gain, 40);
    check("R3", int'(gain), m_gain);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule